// File: doc/BRIEF.md
# Multi-pass disparity winner selector

This block chooses, for every pixel of an image row, the disparity with the lowest matching cost when the full disparity range is too wide to score in one step. The range is split into groups of `GROUP` consecutive disparities. Each accepted input beat delivers one group of SAD values for one pixel. The range is covered in several passes over the row, and one pass is `DEPTH` beats long. Per-pixel progress lives in an internal row buffer. Each beat reads the pixel's record, merges the new group into it, and writes the result back.

A record holds the winning disparity and its SAD. It also holds the SADs of the two neighbouring disparities, which a later stage uses for sub-pixel interpolation. A runner-up SAD taken only over disparities that are not next to the winner serves a later uniqueness test. One spare slot keeps the lowest-disparity SAD of the previous group, so that a winner found at the top of a group still gets its upper neighbour. On the final pass the merged record is not written back. It is registered onto the outputs together with a valid flag.

Top module: `disp_sel_top`

## Requirements
- R1: The reported disparity is the minimum-SAD disparity over all `NUM_DISP` disparities. Within one group, a tie goes to the lowest lane. Across passes, a tie keeps the held candidate, which is the higher disparity seen earlier. `out_best` is that minimum SAD.
- R2: Passes use base disparities `NUM_DISP-GROUP`, `NUM_DISP-2*GROUP`, and so on down to 0. Lane i of `in_sad` (bits `i*SAD_W +: SAD_W`) carries disparity base+i. The pixel address runs 0 to `DEPTH-1`, where `DEPTH = IMG_W-(NUM_DISP-1)-(WIN-1)`, and then wraps, which ends the pass. After the base-0 pass the next beat starts a new frame.
- R3: `out_valid` is 1 in the cycle after each accepted beat of the base-0 pass and 0 in every other cycle.
- R4: `out_lo` and `out_hi` are the SADs at the winner minus 1 and the winner plus 1. When that disparity does not exist (winner 0 or winner `NUM_DISP-1`), the value is all ones (`2^SAD_W-1`).
- R5: `out_runner` is the minimum SAD over all disparities whose distance from the winner is more than 1.
- R6: On the first pass of a frame the buffered record has no effect, so the results of a frame do not depend on any earlier frame.
- R7: Synchronous reset clears the outputs to 0 and `out_valid` to 0. Sequencing restarts at the first pass with address 0.
- R8: A cycle with `in_valid` low does not advance the address or pass, drives `out_valid` to 0, and leaves the result outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat strobe |
| in_sad | input | GROUP*SAD_W | SADs of the current group, lane i at bits i*SAD_W |
| out_valid | output | 1 | Result valid |
| out_disp | output | $clog2(NUM_DISP) | Winning disparity |
| out_best | output | SAD_W | SAD of the winner |
| out_lo | output | SAD_W | SAD at winner minus 1 |
| out_hi | output | SAD_W | SAD at winner plus 1 |
| out_runner | output | SAD_W | Runner-up SAD away from the winner |

## Verification
The results for a pixel appear on the registered outputs at the clock edge that accepts that pixel's base-0 beat. They can be read one edge after the beat is presented and stay valid for exactly that cycle. The bench presents each beat half a cycle before an edge and samples 2 ns after the edge. It then compares all five result fields with a brute-force scan over every disparity of that pixel. During idle cycles and earlier passes it checks that `out_valid` stays low and that the last result is held.

// File: rtl/disp_sel_mintree.sv
module disp_sel_mintree #(
    parameter int N = 4,
    parameter int W = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N*W-1:0] vals,
    output logic [W-1:0]   min_val,
    output logic [IW-1:0]  min_idx
);
    localparam int LEAVES = 1 << IW;
    localparam int NODES  = 2 * LEAVES - 1;

    logic [W-1:0]  nv [NODES];
    logic [IW-1:0] ni [NODES];

    // leaves; unused padding leaves hold the largest value
    for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
        if (j < N) begin : g_real
            assign nv[LEAVES-1+j] = vals[j*W +: W];
        end else begin : g_pad
            assign nv[LEAVES-1+j] = '1;
        end
        assign ni[LEAVES-1+j] = IW'(j);
    end

    // inner nodes: left child (lower index) wins a tie (R1)
    for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
        assign nv[n] = (nv[2*n+2] < nv[2*n+1]) ? nv[2*n+2] : nv[2*n+1];
        assign ni[n] = (nv[2*n+2] < nv[2*n+1]) ? ni[2*n+2] : ni[2*n+1];
    end

    assign min_val = nv[0];
    assign min_idx = ni[0];
endmodule

// File: rtl/disp_sel_ctrl.sv
module disp_sel_ctrl #(
    parameter int NUM_DISP = 16,
    parameter int GROUP    = 4,
    parameter int DEPTH    = 7,
    parameter int DISP_W   = 4,
    parameter int ADDR_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic [DISP_W-1:0] base,
    output logic [ADDR_W-1:0] addr,
    output logic              first,
    output logic              last
);
    localparam logic [DISP_W-1:0] TOP_BASE = DISP_W'(NUM_DISP - GROUP);
    localparam logic [DISP_W-1:0] STEP     = DISP_W'(GROUP);
    localparam logic [ADDR_W-1:0] ADDR_END = ADDR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DISP_W-1:0] base;
        logic [ADDR_W-1:0] addr;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (in_valid) begin
            if (st_q.addr == ADDR_END) begin
                st_d.addr = '0;
                st_d.base = (st_q.base == '0) ? TOP_BASE : st_q.base - STEP;
            end else begin
                st_d.addr = st_q.addr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{base: TOP_BASE, addr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign base  = st_q.base;
    assign addr  = st_q.addr;
    assign first = (st_q.base == TOP_BASE);
    assign last  = (st_q.base == '0);
endmodule

// File: rtl/disp_sel_rowbuf.sv
module disp_sel_rowbuf #(
    parameter int DEPTH  = 7,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 84
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    assign rd_data = mem[addr];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wr_data;
        end
    end
endmodule

// File: rtl/disp_sel_merge.sv
module disp_sel_merge #(
    parameter int NUM_DISP = 16,
    parameter int GROUP    = 4,
    parameter int SAD_W    = 16,
    parameter int DISP_W   = 4,
    localparam int REC_W   = DISP_W + 5 * SAD_W
) (
    input  logic [DISP_W-1:0]      base,
    input  logic                   first,
    input  logic [REC_W-1:0]       rec_rd,
    input  logic [GROUP*SAD_W-1:0] grp,
    output logic [REC_W-1:0]       rec_wr
);
    localparam int IW = (GROUP > 1) ? $clog2(GROUP) : 1;
    localparam logic [SAD_W-1:0] ONES = '1;

    typedef struct packed {
        logic [DISP_W-1:0] disp;
        logic [SAD_W-1:0]  best;
        logic [SAD_W-1:0]  lo;
        logic [SAD_W-1:0]  hi;
        logic [SAD_W-1:0]  extra;   // lane-0 SAD of the previous group
        logic [SAD_W-1:0]  runner;
    } rec_t;

    rec_t              held, nxt;
    logic [SAD_W-1:0]  g [GROUP];
    logic [SAD_W-1:0]  gmin, rmin, old_min;
    logic [IW-1:0]     k, kp1, km1;
    logic              take, adj_prev, k_top;
    logic [GROUP-1:0]  mask;

    for (genvar i = 0; i < GROUP; i++) begin : g_lane
        assign g[i] = grp[i*SAD_W +: SAD_W];
    end

    disp_sel_mintree #(.N(GROUP), .W(SAD_W)) u_win (
        .vals    (grp),
        .min_val (gmin),
        .min_idx (k)
    );

    // decision and runner-up lane mask
    always_comb begin
        held = first ? '{disp: '0, best: ONES, lo: ONES, hi: ONES, extra: ONES, runner: ONES}
                     : rec_t'(rec_rd);
        adj_prev = !first && ({1'b0, held.disp} == ({1'b0, base} + (DISP_W+1)'(GROUP)));
        take  = first || (gmin < held.best);
        k_top = (int'(k) == GROUP - 1);
        mask  = '1;
        if (take) begin
            for (int i = 0; i < GROUP; i++) begin
                if ((i >= int'(k) - 1) && (i <= int'(k) + 1)) mask[i] = 1'b0;
            end
        end else if (adj_prev) begin
            mask[GROUP-1] = 1'b0;
        end
    end

    // smallest SAD in the group among lanes not next to the winner (R5)
    always_comb begin
        rmin = ONES;
        for (int i = 0; i < GROUP; i++) begin
            if (mask[i] && (g[i] < rmin)) rmin = g[i];
        end
    end

    always_comb begin
        kp1 = k_top ? k : k + 1'b1;
        km1 = (k == '0) ? k : k - 1'b1;
        nxt = held;
        nxt.extra = g[0];
        if (take) begin
            nxt.disp = base + DISP_W'(k);
            nxt.best = gmin;
            nxt.hi   = k_top ? held.extra : g[kp1];         // R4
            nxt.lo   = (k == '0) ? ONES : g[km1];           // R4, filled next pass
            if (k_top && adj_prev) begin
                old_min = (held.runner < held.hi) ? held.runner : held.hi;
            end else begin
                old_min = held.best;
            end
            nxt.runner = (rmin < old_min) ? rmin : old_min;
        end else begin
            old_min = held.runner;
            if (adj_prev) nxt.lo = g[GROUP-1];
            nxt.runner = (rmin < old_min) ? rmin : old_min;
        end
    end

    assign rec_wr = nxt;
endmodule

// File: rtl/disp_sel_top.sv
module disp_sel_top #(
    parameter int NUM_DISP = 16,
    parameter int GROUP    = 4,
    parameter int SAD_W    = 16,
    parameter int IMG_W    = 24,
    parameter int WIN      = 3,
    localparam int DISP_W  = $clog2(NUM_DISP)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [GROUP*SAD_W-1:0] in_sad,
    output logic                   out_valid,
    output logic [DISP_W-1:0]      out_disp,
    output logic [SAD_W-1:0]       out_best,
    output logic [SAD_W-1:0]       out_lo,
    output logic [SAD_W-1:0]       out_hi,
    output logic [SAD_W-1:0]       out_runner
);
    localparam int DEPTH  = IMG_W - (NUM_DISP - 1) - (WIN - 1);
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int REC_W  = DISP_W + 5 * SAD_W;

    typedef struct packed {
        logic [DISP_W-1:0] disp;
        logic [SAD_W-1:0]  best;
        logic [SAD_W-1:0]  lo;
        logic [SAD_W-1:0]  hi;
        logic [SAD_W-1:0]  extra;
        logic [SAD_W-1:0]  runner;
    } rec_t;

    typedef struct packed {
        logic              valid;
        logic [DISP_W-1:0] disp;
        logic [SAD_W-1:0]  best;
        logic [SAD_W-1:0]  lo;
        logic [SAD_W-1:0]  hi;
        logic [SAD_W-1:0]  runner;
    } out_t;

    logic [DISP_W-1:0] base;
    logic [ADDR_W-1:0] addr;
    logic              first, last;
    logic [REC_W-1:0]  rec_rd, rec_wr;
    rec_t              rec_new;
    out_t              out_d, out_q;

    disp_sel_ctrl #(
        .NUM_DISP (NUM_DISP), .GROUP (GROUP), .DEPTH (DEPTH),
        .DISP_W (DISP_W), .ADDR_W (ADDR_W)
    ) u_ctrl (
        .clk (clk), .rst (rst), .in_valid (in_valid),
        .base (base), .addr (addr), .first (first), .last (last)
    );

    disp_sel_rowbuf #(.DEPTH (DEPTH), .ADDR_W (ADDR_W), .DATA_W (REC_W)) u_buf (
        .clk     (clk),
        .wr_en   (in_valid && !last),
        .addr    (addr),
        .wr_data (rec_wr),
        .rd_data (rec_rd)
    );

    disp_sel_merge #(
        .NUM_DISP (NUM_DISP), .GROUP (GROUP), .SAD_W (SAD_W), .DISP_W (DISP_W)
    ) u_merge (
        .base (base), .first (first), .rec_rd (rec_rd), .grp (in_sad), .rec_wr (rec_wr)
    );

    assign rec_new = rec_t'(rec_wr);

    always_comb begin
        out_d       = out_q;
        out_d.valid = in_valid && last;
        if (in_valid && last) begin
            out_d.disp   = rec_new.disp;
            out_d.best   = rec_new.best;
            out_d.lo     = rec_new.lo;
            out_d.hi     = rec_new.hi;
            out_d.runner = rec_new.runner;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid  = out_q.valid;
    assign out_disp   = out_q.disp;
    assign out_best   = out_q.best;
    assign out_lo     = out_q.lo;
    assign out_hi     = out_q.hi;
    assign out_runner = out_q.runner;
endmodule

// File: rtl/disp_sel_chk.sv
module disp_sel_chk #(
    parameter int SAD_W  = 16,
    parameter int DEPTH  = 7,
    parameter int DISP_W = 4,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              out_valid,
    input logic [DISP_W-1:0] out_disp,
    input logic [SAD_W-1:0]  out_best,
    input logic [SAD_W-1:0]  out_lo,
    input logic [SAD_W-1:0]  out_hi,
    input logic [SAD_W-1:0]  out_runner,
    input logic [ADDR_W-1:0] addr
);
    AST_VALID_NEEDS_BEAT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid)); // R3

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_disp) && $stable(out_best))); // R8

    AST_BEST_BELOW_NEIGHBOURS: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_best <= out_lo) && (out_best <= out_hi))); // R1

    AST_RUNNER_NOT_BELOW_BEST: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_runner >= out_best)); // R5

    AST_EDGE_LO_ONES: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_disp == '0)) |-> (out_lo == '1)); // R4

    AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(addr) < DEPTH); // R2

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (int'(addr) != DEPTH - 1)) |=> (addr == $past(addr) + 1'b1)); // R2
endmodule

bind disp_sel_top disp_sel_chk #(
    .SAD_W (SAD_W), .DEPTH (DEPTH), .DISP_W (DISP_W), .ADDR_W (ADDR_W)
) u_chk (
    .clk (clk), .rst (rst), .in_valid (in_valid), .out_valid (out_valid),
    .out_disp (out_disp), .out_best (out_best), .out_lo (out_lo),
    .out_hi (out_hi), .out_runner (out_runner), .addr (addr)
);

// File: tb/tb_disp_sel_top.sv
module tb_disp_sel_top;
    localparam int ND    = 16;
    localparam int G     = 4;
    localparam int SW    = 16;
    localparam int IMG   = 24;
    localparam int WIN   = 3;
    localparam int DEPTH = IMG - (ND - 1) - (WIN - 1);
    localparam int NP    = ND / G;
    localparam int ONES  = (1 << SW) - 1;

    // {centre of V-shaped cost, disp, best, lo, hi, runner}
    localparam int TAB [DEPTH][6] = '{
        '{0,  0,  100, ONES, 110,  120},
        '{15, 15, 100, 110,  ONES, 120},
        '{4,  4,  100, 110,  110,  120},
        '{3,  3,  100, 110,  110,  120},
        '{8,  8,  100, 110,  110,  120},
        '{11, 11, 100, 110,  110,  120},
        '{7,  7,  100, 110,  110,  120}
    };

    logic            clk = 1'b0;
    logic            rst;
    logic            in_valid;
    logic [G*SW-1:0] in_sad;
    logic            out_valid;
    logic [3:0]      out_disp;
    logic [SW-1:0]   out_best, out_lo, out_hi, out_runner;

    always #4 clk = ~clk;

    disp_sel_top #(.NUM_DISP(ND), .GROUP(G), .SAD_W(SW), .IMG_W(IMG), .WIN(WIN)) dut (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_sad (in_sad),
        .out_valid (out_valid), .out_disp (out_disp), .out_best (out_best),
        .out_lo (out_lo), .out_hi (out_hi), .out_runner (out_runner)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int pix [DEPTH][ND];
    int got [DEPTH][5];
    int prev_disp = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // brute-force scan over every disparity
    task automatic ref_model(input int a, output int w, output int b,
                             output int lo, output int hi, output int rn);
        w = -1;
        for (int p = 0; p < NP; p++) begin
            int bs = ND - G * (p + 1);
            int gi = bs;
            for (int i = 1; i < G; i++) if (pix[a][bs+i] < pix[a][gi]) gi = bs + i;
            if (w < 0 || pix[a][gi] < pix[a][w]) w = gi;
        end
        b  = pix[a][w];
        lo = (w > 0) ? pix[a][w-1] : ONES;
        hi = (w < ND - 1) ? pix[a][w+1] : ONES;
        rn = ONES;
        for (int d = 0; d < ND; d++)
            if ((d < w - 1 || d > w + 1) && pix[a][d] < rn) rn = pix[a][d];
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #2;
        chk("R8 idle valid low", int'(out_valid), 0);
        chk("R8 idle result held", int'(out_disp), prev_disp);
    endtask

    task automatic run_frame(input int idle_max);
        for (int p = 0; p < NP; p++) begin
            int bs = ND - G * (p + 1);
            for (int a = 0; a < DEPTH; a++) begin
                repeat ($urandom_range(0, idle_max)) idle_cycle();
                @(negedge clk);
                in_valid = 1'b1;
                for (int i = 0; i < G; i++) in_sad[i*SW +: SW] = SW'(pix[a][bs+i]);
                @(posedge clk);
                #2;
                if (p == NP - 1) begin
                    int w, b, lo, hi, rn;
                    ref_model(a, w, b, lo, hi, rn);
                    chk("R3 valid on last pass", int'(out_valid), 1);
                    chk("R1 disparity", int'(out_disp), w);
                    chk("R1 best", int'(out_best), b);
                    chk("R4 lo", int'(out_lo), lo);
                    chk("R4 hi", int'(out_hi), hi);
                    chk("R5 runner", int'(out_runner), rn);
                    got[a] = '{int'(out_disp), int'(out_best), int'(out_lo),
                               int'(out_hi), int'(out_runner)};
                    prev_disp = int'(out_disp);
                end else begin
                    chk("R2 R3 valid low in earlier pass", int'(out_valid), 0);
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        in_sad = '0;
        repeat (3) @(posedge clk);
        #2;
        chk("R7 reset valid", int'(out_valid), 0);
        chk("R7 reset disp", int'(out_disp), 0);
        chk("R7 reset best", int'(out_best), 0);
        chk("R7 reset runner", int'(out_runner), 0);
        @(negedge clk);
        rst = 1'b0;

        // all-zero frame leaves zero records in the buffer
        for (int a = 0; a < DEPTH; a++) for (int d = 0; d < ND; d++) pix[a][d] = 0;
        run_frame(0);

        // vector table: V-shaped costs; R6 stale zeros must not win
        for (int a = 0; a < DEPTH; a++)
            for (int d = 0; d < ND; d++)
                pix[a][d] = 100 + 10 * ((d > TAB[a][0]) ? d - TAB[a][0] : TAB[a][0] - d);
        run_frame(0);
        for (int a = 0; a < DEPTH; a++) begin
            chk("R6 table disp", got[a][0], TAB[a][1]);
            chk("R1 table best", got[a][1], TAB[a][2]);
            chk("R4 table lo", got[a][2], TAB[a][3]);
            chk("R4 table hi", got[a][3], TAB[a][4]);
            chk("R5 table runner", got[a][4], TAB[a][5]);
        end

        // ties
        for (int a = 0; a < DEPTH; a++)
            for (int d = 0; d < ND; d++) pix[a][d] = $urandom_range(0, 15);
        for (int d = 0; d < ND; d++) begin
            pix[0][d] = 50;
            pix[1][d] = (d == 13 || d == 2) ? 30 : 200;
            pix[2][d] = (d == 5 || d == 6) ? 20 : 90;
        end
        run_frame(0);
        chk("R1 tie all equal", got[0][0], 12);
        chk("R1 tie across passes", got[1][0], 13);
        chk("R1 tie within group", got[2][0], 5);
        chk("R5 tie across passes runner", got[1][4], 30);

        // random frames with idle gaps
        for (int f = 0; f < 6; f++) begin
            for (int a = 0; a < DEPTH; a++)
                for (int d = 0; d < ND; d++)
                    pix[a][d] = (f < 3) ? $urandom_range(0, 20) : $urandom_range(0, ONES);
            run_frame(2);
        end

        // reset in the middle of a frame
        for (int n = 0; n < 10; n++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sad = {$urandom, $urandom};
        end
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(posedge clk);
        #2;
        chk("R7 mid reset valid", int'(out_valid), 0);
        chk("R7 mid reset disp", int'(out_disp), 0);
        prev_disp = 0;
        @(negedge clk);
        rst = 1'b0;
        for (int a = 0; a < DEPTH; a++)
            for (int d = 0; d < ND; d++) pix[a][d] = $urandom_range(0, 40);
        run_frame(1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule